// File: doc/BRIEF.md
# Serial Peripheral Interface Controller with Master Demotion

This block is an 8-bit serial peripheral interface port run by a single control register. Software reaches it through a small register bus with three locations: control, status and data. In master mode the block divides the system clock to make the serial clock. It shifts a byte out on its master-out line and shifts a byte in from its master-in line. In slave mode it follows an external serial clock while the select input is low. That clock and the slave data input pass through a two-flop synchroniser before use.

At run time software picks the bit order, the clock idle level, and which edge samples and which edge sets up data. When a byte is finished the block sets a completion flag. An interrupt line follows that flag when the local interrupt enable and a global interrupt enable input are both set. The select input may go low while the block is master. The block then treats this as a bus conflict: it drops back to slave mode, aborts the transfer and sets the completion flag. Master mode comes back only when software writes the master bit again.

Top module: `spi_unit`

## Requirements
- R1: After reset the control and status registers read 0x00, `sck_out` is low, and `mosi_out` and `irq` are low.
- R2: Address 0 is the control register and every bit reads back what was written. Bit 7 is interrupt enable, bit 6 port enable, bit 5 LSB-first, bit 4 master, bit 3 clock idle-high (CPOL), bit 2 sample-on-trailing (CPHA), and bits 1:0 rate code. Address 1 is status, with the completion flag in bit 7 and zeros elsewhere. Address 2 is data; a write loads the transmit byte and a read returns the received byte.
- R3: While bit 6 of control is 0, a write to the data register starts nothing: `sck_out` stays at its idle level, `mosi_out` stays low and the flag stays 0.
- R4: With bit 5 set the least significant bit goes out first; with it clear the most significant bit goes out first. Received bits are placed in the same order, so a looped-back byte reads back unchanged.
- R5: `sck_out` rests at the level of CPOL. The first edge of each bit (the leading edge) moves away from that level, and the second edge (the trailing edge) returns to it.
- R6: With CPHA 0, data is sampled on leading edges and changed on trailing edges, and the first bit is on `mosi_out` as soon as the transfer starts. With CPHA 1, data is changed on leading edges and sampled on trailing edges. Data never changes between edges.
- R7: In master mode each half period of `sck_out` lasts 2, 8, 32 or 64 system clocks for rate codes 0, 1, 2 and 3. The full SCK period is therefore 4, 16, 64 or 128 system clocks.
- R8: The completion flag sets once the eighth bit has been sampled. To clear it, read status while the flag is 1 and then access the data register. A data access with no status read before it leaves the flag set.
- R9: If `ss_n` goes low while the port is enabled as master, the master bit clears, the flag sets and the transfer stops with `sck_out` at idle. Writing the master bit again restores master mode.
- R10: `irq` is 1 only while the flag, the interrupt enable bit and `glb_irq_en` are all 1.
- R11: In slave mode, with `ss_n` low, the port samples `mosi_in` and drives `miso_out` on the edges of `sck_in` chosen by CPOL and CPHA. It receives a full byte and returns its preloaded byte. `miso_out` is low while `ss_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (drives the flag-clear sequence) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| glb_irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_in | input | 1 | Serial clock from the remote master (slave mode) |
| sck_out | output | 1 | Generated serial clock (master mode) |
| mosi_in | input | 1 | Serial data in (slave mode) |
| mosi_out | output | 1 | Serial data out (master mode) |
| miso_in | input | 1 | Serial data in (master mode) |
| miso_out | output | 1 | Serial data out (slave mode) |
| ss_n | input | 1 | Active-low select; a conflict indication in master mode |

## Verification
The assertions assume that software does not write the control or data register while a master byte is on the wire. They also assume that `ss_n` stays high whenever a master transfer is meant to run. In addition, `sck_in` must change no faster than every two system clocks, and `mosi_in` may change only together with a setup edge. To stay inside these limits, the bench waits out each transfer before its next register write. It pulls `ss_n` low in master mode only in the deliberate conflict scenario. As the remote master it toggles `sck_in` every eight system clocks and changes `mosi_in` only on its own setup edges.

// File: rtl/spi_unit_pkg.sv
// Package: shared register layout and address map of the serial port.
// Assumes an 8-bit register bus.
package spi_unit_pkg;

    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_DATA = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       irq_en;
        logic       enable;
        logic       lsb_first;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

endpackage

// File: rtl/spi_unit_sync.sv
// Module: two-flop synchroniser for a group of asynchronous inputs.
// Assumes each input bit is independent or changes slowly enough
// that the bits arrive in the same cycle.
module spi_unit_sync #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta_q;

    // Two register stages toward the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/spi_unit_clkgen.sv
// Module: master serial clock timer. While run is high it pulses tick
// once every half period. The half period comes from the rate code:
// BASE_HALF * {1, 4, 16, 32} system clocks.
// Assumes run drops to 0 between transfers so that each transfer
// starts from a full half period.
module spi_unit_clkgen #(
    parameter int BASE_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);

    localparam int MAX_HALF = BASE_HALF * 32;
    localparam int CNT_W    = $clog2(MAX_HALF);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;

    // Look up the terminal count for the selected rate.
    always_comb begin
        case (rate)
            2'd0:    half_m1 = CNT_W'(BASE_HALF - 1);
            2'd1:    half_m1 = CNT_W'(BASE_HALF * 4 - 1);
            2'd2:    half_m1 = CNT_W'(BASE_HALF * 16 - 1);
            default: half_m1 = CNT_W'(MAX_HALF - 1);
        endcase
    end

    assign tick = run && (cnt_q == half_m1);

    // Count system clocks inside the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_unit_shifter.sv
// Module: the shift register used in both modes. On a sample event it
// shifts in_bit in. On a setup event it moves the next outgoing bit
// into out_bit. byte_done pulses on the last sample of a byte.
// Assumes sample_ev and setup_ev never arrive in the same cycle.
// Priority: load, then clear, then prime, then events.
module spi_unit_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             prime,
    input  logic             lsb_first,
    input  logic             sample_ev,
    input  logic             setup_ev,
    input  logic             in_bit,
    output logic [WIDTH-1:0] data,
    output logic             out_bit,
    output logic             byte_done
);

    localparam int CNT_W = $clog2(WIDTH);
    localparam int LAST  = WIDTH - 1;

    logic [WIDTH-1:0] sr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [WIDTH-1:0] shifted;
    logic             head_sr;
    logic             head_ld;

    assign head_sr = lsb_first ? sr_q[0] : sr_q[WIDTH-1];
    assign head_ld = lsb_first ? load_data[0] : load_data[WIDTH-1];
    assign shifted = lsb_first ? {in_bit, sr_q[WIDTH-1:1]}
                               : {sr_q[WIDTH-2:0], in_bit};
    assign byte_done = sample_ev && !load && !clear && !prime &&
                       (cnt_q == CNT_W'(LAST));
    assign data = sr_q;

    // Load, shift and bit-count bookkeeping for one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q    <= '0;
            cnt_q   <= '0;
            out_bit <= 1'b0;
        end else if (load) begin
            sr_q    <= load_data;
            out_bit <= head_ld;
            cnt_q   <= '0;
        end else if (clear) begin
            cnt_q   <= '0;
        end else if (prime) begin
            out_bit <= head_sr;
            cnt_q   <= '0;
        end else begin
            if (sample_ev) begin
                sr_q  <= shifted;
                cnt_q <= (cnt_q == CNT_W'(LAST)) ? '0 : cnt_q + 1'b1;
            end
            if (setup_ev) begin
                out_bit <= head_sr;
            end
        end
    end

endmodule

// File: rtl/spi_unit.sv
// Module: top of the serial port. It holds the control register, the
// completion flag with its two-step clear, the master transfer
// sequencer and the conflict detection on the select input. It also
// maps the leading and trailing clock edges to sample and setup events
// for either mode.
// Assumes: no control or data writes while a master byte is in flight,
// and sck_in at most a quarter of the system clock rate.
module spi_unit
    import spi_unit_pkg::*;
#(
    parameter int BASE_HALF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             glb_irq_en,
    output logic             irq,
    input  logic             sck_in,
    output logic             sck_out,
    input  logic             mosi_in,
    output logic             mosi_out,
    input  logic             miso_in,
    output logic             miso_out,
    input  logic             ss_n
);

    localparam int EDGES  = 2 * REG_W;
    localparam int EDGE_W = $clog2(EDGES);

    ctrl_t             ctrl_q;
    logic              flag_q;
    logic              arm_q;
    logic              busy_q;
    logic              phase_q;
    logic [EDGE_W-1:0] edge_q;
    logic [2:0]        sync_q;
    logic              ss_s, mosi_s, sck_s;
    logic              sck_prev_q, ss_prev_q;
    logic              tick;
    logic              is_master, is_slave, fault, slv_act;
    logic              lead_ev, trail_ev, sample_ev, setup_ev;
    logic              data_acc, data_wr, stat_rd, start, load, prime, clear;
    logic              byte_done, out_bit, in_bit;
    logic [REG_W-1:0]  shift_data;

    spi_unit_sync #(
        .WIDTH  (3),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ss_n, mosi_in, sck_in}),
        .q    (sync_q)
    );

    assign ss_s   = sync_q[2];
    assign mosi_s = sync_q[1];
    assign sck_s  = sync_q[0];

    // Keep last synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev_q <= 1'b0;
            ss_prev_q  <= 1'b1;
        end else begin
            sck_prev_q <= sck_s;
            ss_prev_q  <= ss_s;
        end
    end

    assign is_master = ctrl_q.enable && ctrl_q.master;
    assign is_slave  = ctrl_q.enable && !ctrl_q.master;
    assign fault     = is_master && !ss_s;
    assign slv_act   = is_slave && !ss_s;

    // Map master ticks or slave clock transitions onto leading/trailing edges.
    always_comb begin
        if (is_master) begin
            lead_ev  = tick && !phase_q;
            trail_ev = tick && phase_q;
        end else begin
            lead_ev  = slv_act && (ctrl_q.cpol ? (sck_prev_q && !sck_s)
                                               : (!sck_prev_q && sck_s));
            trail_ev = slv_act && (ctrl_q.cpol ? (!sck_prev_q && sck_s)
                                               : (sck_prev_q && !sck_s));
        end
    end

    assign sample_ev = ctrl_q.cpha ? trail_ev : lead_ev;
    assign setup_ev  = ctrl_q.cpha ? lead_ev : trail_ev;

    assign data_acc = (bus_wr || bus_rd) && (bus_addr == ADDR_DATA);
    assign data_wr  = bus_wr && (bus_addr == ADDR_DATA);
    assign stat_rd  = bus_rd && (bus_addr == ADDR_STAT);
    assign load     = data_wr && !busy_q;
    assign start    = load && is_master && ss_s;
    assign prime    = is_slave && ss_prev_q && !ss_s;
    assign clear    = !ctrl_q.enable || (is_slave && ss_s) || fault;
    assign in_bit   = is_master ? miso_in : mosi_s;

    spi_unit_clkgen #(
        .BASE_HALF(BASE_HALF)
    ) u_clkgen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy_q),
        .rate (ctrl_q.rate),
        .tick (tick)
    );

    spi_unit_shifter #(
        .WIDTH(REG_W)
    ) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .load     (load),
        .load_data(bus_wdata),
        .prime    (prime),
        .lsb_first(ctrl_q.lsb_first),
        .sample_ev(sample_ev),
        .setup_ev (setup_ev),
        .in_bit   (in_bit),
        .data     (shift_data),
        .out_bit  (out_bit),
        .byte_done(byte_done)
    );

    // Control register: software writes, hardware demotion on conflict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_wr && (bus_addr == ADDR_CTRL)) begin
            ctrl_q <= ctrl_t'(bus_wdata);
        end else if (fault) begin
            ctrl_q.master <= 1'b0;
        end
    end

    // Completion flag and the arm bit of its read-status-then-data clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else if (byte_done || fault) begin
            flag_q <= 1'b1;
            arm_q  <= 1'b0;
        end else if (data_acc) begin
            if (arm_q) begin
                flag_q <= 1'b0;
            end
            arm_q <= 1'b0;
        end else if (stat_rd && flag_q) begin
            arm_q <= 1'b1;
        end
    end

    // Master sequencer: count sixteen clock edges per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            edge_q  <= '0;
        end else if (!is_master || fault) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            edge_q  <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            edge_q  <= '0;
        end else if (tick) begin
            phase_q <= !phase_q;
            edge_q  <= edge_q + 1'b1;
            if (edge_q == EDGE_W'(EDGES - 1)) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign sck_out  = (busy_q && phase_q) ^ ctrl_q.cpol;
    assign mosi_out = is_master && out_bit;
    assign miso_out = slv_act && out_bit;
    assign irq      = flag_q && ctrl_q.irq_en && glb_irq_en;

    // Register read multiplexer.
    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl_q;
            ADDR_STAT: bus_rdata = {flag_q, {(REG_W-1){1'b0}}};
            ADDR_DATA: bus_rdata = shift_data;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_unit_checker.sv
// Module: property checker for the serial port, bound to its top.
// Assumes the usage limits listed in the top module header.
module spi_unit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic       glb_irq_en,
    input logic       irq,
    input logic       sck_out,
    input logic       mosi_out,
    input logic       miso_out,
    input logic [7:0] ctrl_q,
    input logic       flag_q,
    input logic       busy_q,
    input logic       tick,
    input logic       ss_s,
    input logic       byte_done,
    input logic       fault
);

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[6] |-> (sck_out == ctrl_q[3]) && !mosi_out && !miso_out); // R3

    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> sck_out == ctrl_q[3]); // R5

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !tick && ss_s && !bus_wr |=> $stable(mosi_out)); // R6

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(byte_done || fault)); // R8

    AST_FAULT_DEMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[6] && ctrl_q[4] && !ss_s && !(bus_wr && bus_addr == 2'd0)
        |=> !ctrl_q[4] && flag_q && !busy_q); // R9

    AST_IRQ_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_irq_en |-> !irq); // R10

endmodule

bind spi_unit spi_unit_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .glb_irq_en(glb_irq_en),
    .irq       (irq),
    .sck_out   (sck_out),
    .mosi_out  (mosi_out),
    .miso_out  (miso_out),
    .ctrl_q    (ctrl_q),
    .flag_q    (flag_q),
    .busy_q    (busy_q),
    .tick      (tick),
    .ss_s      (ss_s),
    .byte_done (byte_done),
    .fault     (fault)
);

// File: tb/spi_unit_bench.sv
// Directed bench for spi_unit: one task per scenario, each checks itself.
module spi_unit_bench;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam int         SLV_H  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       glb_irq_en = 1'b0;
    logic       irq;
    logic       sck_in = 1'b0;
    logic       sck_out;
    logic       mosi_in = 1'b0;
    logic       mosi_out;
    logic       miso_in;
    logic       miso_out;
    logic       ss_n = 1'b1;

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    assign miso_in = mosi_out;

    always #5 clk = ~clk;

    spi_unit u_spi_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .glb_irq_en(glb_irq_en),
        .irq       (irq),
        .sck_in    (sck_in),
        .sck_out   (sck_out),
        .mosi_in   (mosi_in),
        .mosi_out  (mosi_out),
        .miso_in   (miso_in),
        .miso_out  (miso_out),
        .ss_n      (ss_n)
    );

    task automatic chk(input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    function automatic logic bit_at(input logic [7:0] b, input bit dord, input int i);
        return dord ? b[i] : b[7-i];
    endfunction

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 sck_out after reset", sck_out, 0);
        chk("R1 irq/mosi after reset", {irq, mosi_out}, 0);
        begin
            logic [7:0] rd;
            bus_read(A_CTRL, rd); chk("R1 control after reset", rd, 8'h00);
            bus_read(A_STAT, rd); chk("R1 status after reset", rd, 8'h00);
        end
    endtask

    task automatic t_regs();
        logic [7:0] rd;
        bus_write(A_CTRL, 8'hA5); bus_read(A_CTRL, rd); chk("R2 control readback A5", rd, 8'hA5);
        bus_write(A_CTRL, 8'h5A); bus_read(A_CTRL, rd); chk("R2 control readback 5A", rd, 8'h5A);
        bus_write(A_CTRL, 8'h00);
    endtask

    task automatic t_disabled();
        int toggles = 0;
        int mosi_hi = 0;
        logic prev;
        logic [7:0] rd;
        bus_write(A_CTRL, 8'h18);
        bus_write(A_DATA, 8'h77);
        prev = sck_out;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (sck_out !== prev) toggles++;
            if (mosi_out) mosi_hi++;
            prev = sck_out;
        end
        chk("R3 no clock edges while disabled", toggles, 0);
        chk("R3 sck held idle high", sck_out, 1);
        chk("R3 mosi quiet while disabled", mosi_hi, 0);
        bus_read(A_STAT, rd); chk("R3 no flag while disabled", rd, 8'h00);
        bus_write(A_CTRL, 8'h00);
    endtask

    task automatic master_xfer(input logic [7:0] tx, input bit dord, input bit cpol,
                               input bit cpha, input logic [1:0] rate);
        int half, edges, gap, nsamp;
        bit dir_ok, gap_ok, leading;
        logic prev;
        logic [7:0] got, exp_seq, rd;
        half = (rate == 2'd3) ? 64 : (2 << (2 * rate));
        bus_write(A_CTRL, {1'b0, 1'b1, dord, 1'b1, cpol, cpha, rate});
        bus_write(A_DATA, tx);
        chk("R5 sck at idle level when byte starts", sck_out, cpol);
        if (!cpha) chk("R6 first bit on mosi before first edge", mosi_out, bit_at(tx, dord, 0));
        prev = sck_out; edges = 0; gap = 0; nsamp = 0; dir_ok = 1; gap_ok = 1; got = '0;
        for (int c = 0; c < 4000 && edges < 16; c++) begin
            @(negedge clk);
            gap++;
            if (sck_out !== prev) begin
                edges++;
                leading = (edges % 2) == 1;
                if (leading && (sck_out !== !cpol)) dir_ok = 0;
                if (edges > 1 && gap != half) gap_ok = 0;
                if (leading != cpha && nsamp < 8) begin
                    got[nsamp] = mosi_out;
                    nsamp++;
                end
                gap = 0;
                prev = sck_out;
            end
        end
        for (int i = 0; i < 8; i++) exp_seq[i] = bit_at(tx, dord, i);
        repeat (3) @(negedge clk);
        chk("R5 leading edge leaves idle level", dir_ok, 1);
        chk("R5 sck back at idle after byte", sck_out, cpol);
        chk("R7 half period matches rate code", gap_ok, 1);
        chk("R4 R6 bit sequence at sample edges", got, exp_seq);
        bus_read(A_DATA, rd); chk("R4 looped-back byte", rd, tx);
        bus_read(A_STAT, rd); chk("R8 flag set, data read alone kept it", rd, 8'h80);
        bus_read(A_DATA, rd);
        bus_read(A_STAT, rd); chk("R8 flag cleared by status then data", rd, 8'h00);
    endtask

    task automatic slave_xfer(input logic [7:0] tx, input logic [7:0] pre, input bit dord,
                              input bit cpol, input bit cpha);
        logic [7:0] got, exp_seq, rd;
        bus_write(A_CTRL, {1'b0, 1'b1, dord, 1'b0, cpol, cpha, 2'b00});
        @(negedge clk);
        sck_in = cpol; mosi_in = 1'b0;
        bus_write(A_DATA, pre);
        repeat (4) @(negedge clk);
        chk("R11 miso low while deselected", miso_out, 0);
        ss_n = 1'b0;
        repeat (SLV_H) @(negedge clk);
        got = '0;
        for (int i = 0; i < 8; i++) begin
            if (!cpha) mosi_in = bit_at(tx, dord, i);
            repeat (SLV_H) @(negedge clk);
            if (!cpha) got[i] = miso_out;
            sck_in = !cpol;
            if (cpha) mosi_in = bit_at(tx, dord, i);
            repeat (SLV_H) @(negedge clk);
            if (cpha) got[i] = miso_out;
            sck_in = cpol;
        end
        repeat (SLV_H) @(negedge clk);
        ss_n = 1'b1;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 8; i++) exp_seq[i] = bit_at(pre, dord, i);
        chk("R11 slave returns preloaded byte", got, exp_seq);
        bus_read(A_DATA, rd); chk("R11 R4 slave received byte", rd, tx);
        bus_read(A_STAT, rd); chk("R8 R11 slave flag after eight samples", rd, 8'h80);
        bus_read(A_DATA, rd);
        bus_read(A_STAT, rd); chk("R8 slave flag cleared", rd, 8'h00);
    endtask

    task automatic t_fault();
        logic [7:0] rd;
        glb_irq_en = 1'b1;
        bus_write(A_CTRL, 8'hD1);
        bus_write(A_DATA, 8'hFF);
        repeat (10) @(negedge clk);
        ss_n = 1'b0;
        repeat (4) @(negedge clk);
        ss_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(A_CTRL, rd); chk("R9 master bit cleared by select conflict", rd, 8'hC1);
        chk("R9 sck idle after abort", sck_out, 0);
        chk("R10 irq with flag and both enables", irq, 1);
        bus_read(A_STAT, rd); chk("R9 flag set by conflict", rd, 8'h80);
        bus_read(A_DATA, rd);
        #1 chk("R10 irq drops with flag", irq, 0);
        bus_write(A_CTRL, 8'hD1);
        repeat (4) @(negedge clk);
        bus_read(A_CTRL, rd); chk("R9 master restored by rewrite", rd, 8'hD1);
        bus_write(A_CTRL, 8'h00);
        glb_irq_en = 1'b0;
    endtask

    task automatic t_irq();
        logic [7:0] rd;
        glb_irq_en = 1'b0;
        bus_write(A_CTRL, 8'hD0);
        bus_write(A_DATA, 8'h42);
        repeat (60) @(negedge clk);
        chk("R10 no irq without global enable", irq, 0);
        bus_read(A_STAT, rd); chk("R8 flag after master byte", rd, 8'h80);
        glb_irq_en = 1'b1;
        #1 chk("R10 irq once global enable set", irq, 1);
        bus_write(A_CTRL, 8'h50);
        #1 chk("R10 no irq without local enable", irq, 0);
        bus_read(A_DATA, rd);
        bus_read(A_STAT, rd); chk("R8 flag cleared after irq test", rd, 8'h00);
        glb_irq_en = 1'b0;
        bus_write(A_CTRL, 8'h00);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_disabled();
        master_xfer(8'hA5, 1'b0, 1'b0, 1'b0, 2'd0);
        master_xfer(8'h3C, 1'b1, 1'b0, 1'b1, 2'd1);
        master_xfer(8'h96, 1'b0, 1'b1, 1'b0, 2'd2);
        master_xfer(8'h71, 1'b1, 1'b1, 1'b1, 2'd3);
        slave_xfer(8'h5E, 8'hC3, 1'b0, 1'b0, 1'b0);
        slave_xfer(8'h81, 8'h2B, 1'b1, 1'b1, 1'b1);
        slave_xfer(8'h6D, 8'h94, 1'b0, 1'b1, 1'b0);
        bus_write(A_CTRL, 8'h00);
        t_fault();
        t_irq();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog act=running exp=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule